// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

The controller gathers event pulses from a set of peripheral modules, each owning a small group of sources. Every event latches into a sticky flag, whatever the state of the masks. A request reaches the processor only through three enables in series: one per source, one per module and one global bit. All sources share one programmable vector, and the processor fetches it on any request. No hardware priority exists. Software reads an identification word to find the modules that hold enabled pending flags. It then reads those modules' flag words and clears flags by writing ones.

A flag clear does not remove the request at once. Sources marked asynchronous drop their part of the request one cycle after the clear. Sources marked synchronous hold it for one cycle more. The service routine must wait out that gap before it returns. A parameter chooses the class of each source.

Top module: `sv_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_i[m*N_SRC+s]` sets flag `s` of module `m` at the next clock edge, whatever the source, module and global enables hold.
- R2: `irq_o` is high exactly when some source has its flag (or, for a synchronous source, its one-cycle-delayed flag) set, its source enable set, its module's enable bit set (address 2, bit `m`) and the global enable set (address 1, bit 0).
- R3: The vector register at address 0 is `DATA_W` bits wide, is read and written whole, drives `vec_o`, and changes only on a write to address 0.
- R4: The identification word at address 3 has bit `m` equal to the OR of module `m`'s flags ANDed with its source enables, independent of module and global enables; writes to address 3 change nothing.
- R5: Flags stay set until software writes a 1 to their bit in the module's flag word (address 4+2m); a 0 bit in that write leaves the flag unchanged.
- R6: For an asynchronous source that alone drives the request, `irq_o` is low in the first cycle after the edge that takes the clearing write.
- R7: For a synchronous source (bit `m*N_SRC+s` of `SYNC_SRC` set) that alone drives the request, `irq_o` stays high in the first cycle after the clearing write and is low in the second.
- R8: When an event and a clearing write reach the same flag at the same edge, the flag stays set.
- R9: After reset all flags, source enables, module enables, the global enable and the vector read as zero, and `irq_o` is low.
- R10: Source enables of module `m` are read and written at address 5+2m, bit `s`; unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_MOD*N_SRC | Event pulses, one per source, module-major |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from address |
| irq_o | output | 1 | Request to the processor |
| vec_o | output | DATA_W | Shared interrupt vector |

## Verification
The bench builds the controller with three modules of four sources each. It uses a sync/async mix chosen so that every module holds both classes. For every source it walks all eight combinations of source, module and global enable. At each step it checks the latched flag, the identification bit and the request, and it checks the one-cycle or two-cycle request drop after a clear. The small size makes this sweep complete. It also covers the collision between an event and a clear, the read-only identification word, and the cases where a partial clear has no effect.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADR_VEC  = 0;
  localparam int unsigned ADR_CTRL = 1;
  localparam int unsigned ADR_MEN  = 2;
  localparam int unsigned ADR_ID   = 3;
  localparam int unsigned ADR_BANK = 4;

  function automatic int unsigned flag_adr(int unsigned m);
    return ADR_BANK + 2 * m;
  endfunction

  function automatic int unsigned en_adr(int unsigned m);
    return ADR_BANK + 2 * m + 1;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N_SRC = 8,
  parameter logic [N_SRC-1:0] SYNC_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic             en_we_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] view_o,
  output logic             req_o,
  output logic             pend_o
);
  logic [N_SRC-1:0] flag_q, flag_d_q, en_q, clr;

  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= '0;
      flag_d_q <= '0;
      en_q     <= '0;
    end else begin
      // set dominates clear
      flag_q   <= (flag_q & ~clr) | evt_i;
      flag_d_q <= flag_q;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (SYNC_MASK[i]) begin : g_sync
      assign view_o[i] = flag_q[i] | flag_d_q[i];
    end else begin : g_async
      assign view_o[i] = flag_q[i];
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign req_o  = |(view_o & en_q);
  assign pend_o = |(flag_q & en_q);
endmodule

// File: rtl/irq_glb_regs.sv
module irq_glb_regs #(
  parameter int unsigned N_MOD  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              gen_o,
  output logic [N_MOD-1:0]  men_o
);
  import irq_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o <= '0;
      gen_o <= 1'b0;
      men_o <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(ADR_VEC))  vec_o <= wdata_i;
      if (addr_i == ADDR_W'(ADR_CTRL)) gen_o <= wdata_i[0];
      if (addr_i == ADDR_W'(ADR_MEN))  men_o <= wdata_i[N_MOD-1:0];
    end
  end
endmodule

// File: rtl/sv_irq_ctrl.sv
module sv_irq_ctrl #(
  parameter int unsigned N_MOD  = 8,
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [N_MOD*N_SRC-1:0] SYNC_SRC = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_MOD*N_SRC-1:0] evt_i,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  output logic                   irq_o,
  output logic [DATA_W-1:0]      vec_o
);
  import irq_pkg::*;

  localparam int unsigned N_ALL = N_MOD * N_SRC;

  logic             gen;
  logic [N_MOD-1:0] men, mod_req, mod_pend;
  logic [N_SRC-1:0] bank_flag [N_MOD];
  logic [N_SRC-1:0] bank_en   [N_MOD];
  logic [N_ALL-1:0] flag_all, view_all;

  irq_glb_regs #(.N_MOD(N_MOD), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_glb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .vec_o  (vec_o),
    .gen_o  (gen),
    .men_o  (men)
  );

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    logic clr_we, en_we;
    assign clr_we = reg_we_i && (reg_addr_i == ADDR_W'(flag_adr(m)));
    assign en_we  = reg_we_i && (reg_addr_i == ADDR_W'(en_adr(m)));

    irq_src_bank #(
      .N_SRC    (N_SRC),
      .SYNC_MASK(SYNC_SRC[m*N_SRC +: N_SRC])
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[m*N_SRC +: N_SRC]),
      .clr_we_i(clr_we),
      .en_we_i (en_we),
      .wdata_i (reg_wdata_i[N_SRC-1:0]),
      .flag_o  (bank_flag[m]),
      .en_o    (bank_en[m]),
      .view_o  (view_all[m*N_SRC +: N_SRC]),
      .req_o   (mod_req[m]),
      .pend_o  (mod_pend[m])
    );
    assign flag_all[m*N_SRC +: N_SRC] = bank_flag[m];
  end

  assign irq_o = gen & |(men & mod_req);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADR_VEC))  reg_rdata_o = vec_o;
    if (reg_addr_i == ADDR_W'(ADR_CTRL)) reg_rdata_o[0] = gen;
    if (reg_addr_i == ADDR_W'(ADR_MEN))  reg_rdata_o[N_MOD-1:0] = men;
    if (reg_addr_i == ADDR_W'(ADR_ID))   reg_rdata_o[N_MOD-1:0] = mod_pend;
    for (int m = 0; m < N_MOD; m++) begin
      if (reg_addr_i == ADDR_W'(flag_adr(m))) reg_rdata_o[N_SRC-1:0] = bank_flag[m];
      if (reg_addr_i == ADDR_W'(en_adr(m)))   reg_rdata_o[N_SRC-1:0] = bank_en[m];
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N_ALL  = 64,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_ALL-1:0]  evt_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] vec_o,
  input logic [N_ALL-1:0]  flag_all,
  input logic [N_ALL-1:0]  view_all
);
  assert_evt_sets_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_all & $past(evt_i)) == $past(evt_i)));

  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ((flag_all & $past(flag_all)) == $past(flag_all)));

  assert_req_needs_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (view_all != '0));

  assert_vec_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == '0) |=> (vec_o == $past(reg_wdata_i)));

  assert_vec_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == '0) |=> $stable(vec_o));
endmodule

bind sv_irq_ctrl irq_ctrl_chk #(
  .N_ALL (N_MOD*N_SRC),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .flag_all   (flag_all),
  .view_all   (view_all)
);

// File: tb/sim_sv_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sv_irq_ctrl;
  localparam int unsigned NM = 3;
  localparam int unsigned NS = 4;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 8;
  localparam logic [NM*NS-1:0] SYNC = 12'b1010_0110_0101;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM*NS-1:0] evt = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, vec;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sv_irq_ctrl #(.N_MOD(NM), .N_SRC(NS), .DATA_W(DW), .ADDR_W(AW), .SYNC_SRC(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .vec_o(vec)
  );

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    we = 1'b1; addr = AW'(a); wdata = d;
    tick;
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    addr = AW'(a); #1; d = rdata;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R9 reset state
    check("R9 irq", irq, 0);
    check("R9 vec", vec, 0);
    rd(1, d); check("R9 ctrl", d, 0);
    rd(2, d); check("R9 men", d, 0);
    rd(3, d); check("R9 id", d, 0);
    for (int m = 0; m < NM; m++) begin
      rd(4 + 2*m, d); check("R9 flags", d, 0);
      rd(5 + 2*m, d); check("R10 en", d, 0);
    end
    rd(40, d); check("R10 unmapped", d, 0);

    // R3 vector
    wr(0, 16'hBEEF);
    check("R3 vec_o", vec, 16'hBEEF);
    rd(0, d); check("R3 readback", d, 16'hBEEF);

    // near-exhaustive enable sweep
    for (int m = 0; m < NM; m++) begin
      for (int s = 0; s < NS; s++) begin
        for (int c = 0; c < 8; c++) begin
          logic ie, me, ge, sy;
          ie = c[0]; me = c[1]; ge = c[2];
          sy = SYNC[m*NS+s];
          wr(5 + 2*m, ie ? DW'(1 << s) : '0);
          rd(5 + 2*m, d); check("R10 en rw", d, ie ? (1 << s) : 0);
          wr(2, me ? DW'(1 << m) : '0);
          wr(1, DW'(ge));
          evt = '0; evt[m*NS+s] = 1'b1;
          tick;
          evt = '0;
          rd(4 + 2*m, d); check("R1 flag set", d, 1 << s);
          rd(3, d); check("R4 id", d, ie ? (1 << m) : 0);
          check("R2 irq", irq, ie & me & ge);
          // R5 zero bits in clear word leave flag
          wr(4 + 2*m, ~DW'(1 << s));
          rd(4 + 2*m, d); check("R5 partial clear", d, 1 << s);
          check("R2 irq held", irq, ie & me & ge);
          wr(4 + 2*m, DW'(1 << s));
          rd(4 + 2*m, d); check("R5 clear", d, 0);
          if (sy) check("R7 sync first cycle", irq, ie & me & ge);
          else    check("R6 async drop", irq, 0);
          tick;
          check(sy ? "R7 sync drop" : "R6 async stays low", irq, 0);
        end
      end
    end

    // R4 identification word is read-only
    wr(5, DW'(1));
    evt = '0; evt[0] = 1'b1; tick; evt = '0;
    wr(3, 16'h0000);
    rd(3, d); check("R4 id read-only", d, 1);
    rd(0, d); check("R4 write id no side effect", d, 16'hBEEF);

    // R8 event and clear collide
    addr = AW'(4); wdata = DW'(1); we = 1'b1; evt[0] = 1'b1;
    tick;
    we = 1'b0; evt = '0;
    rd(4, d); check("R8 set wins", d, 1);
    wr(4, DW'(1));
    rd(4, d); check("R8 later clear", d, 0);

    // R1 masked multi-event
    wr(1, '0); wr(2, '0);
    evt = '1; tick; evt = '0;
    for (int m = 0; m < NM; m++) begin
      rd(4 + 2*m, d); check("R1 all flags masked", d, (1 << NS) - 1);
    end
    check("R2 masked no irq", irq, 0);

    finish_run;
  end
endmodule